// File: doc/BRIEF.md
# Transmit Launch and Interrupt Controller

This block is the control and status layer between a radio transceiver's register file and its packet engine. Software writes a launch bit to start sending the frame already loaded in the transmit buffer, and may at the same time ask for an acknowledgement. The packet engine answers with a completion pulse, a failure qualifier and a frame-received pulse. The block latches these as sticky event bits, keeps the outcome of the last transmission, and drives an active-low, level-sensitive host interrupt whenever an event is pending and not disabled.

Register reads and writes come from a serial front end as single-cycle strobes with an address and a byte. Reading the event register returns its contents and clears it in the same access. Read data is registered, so it appears one cycle after the read strobe.

Top module: `txirq_ctrl`

## Requirements
- R1: After reset `irq_n` is 1, `tx_start` and `tx_ack_req` are 0, the event register (address 0x00) reads 0x00 and the disable register (address 0x01) reads 0x09.
- R2: Writing 1 to bit 0 of the launch register (address 0x02) while idle drives `tx_start` high for exactly the one cycle after the write, and bit 0 then reads back 0.
- R3: Bit 2 of the launch register is stored on every write to that register, drives `tx_ack_req` and reads back.
- R4: A launch write made after `tx_start` and before the matching `mac_tx_done` is ignored: no `tx_start` follows; once `mac_tx_done` arrives a new launch is accepted.
- R5: `mac_tx_done` sets event bit 0 and `mac_rx_frame` sets event bit 3; the other event bits read 0 and writes to the event register have no effect.
- R6: A read of the event register returns the contents before the read and clears them; an event pulse in the same cycle as that read stays set and is returned by the next read.
- R7: `irq_n` is 0 exactly while some event bit is set whose disable bit (bit 0 for transmit, bit 3 for receive, 1 = disabled) is 0; only those two disable bits are writable, others read 0.
- R8: The result register (address 0x03) bit 0 holds the `mac_tx_fail` value sampled with the last `mac_tx_done`; 0 after a successful send.
- R9: `reg_rdata` changes only on the cycle after a read strobe and otherwise holds its value.
- R10: A read of an address other than 0x00 to 0x03 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| mac_tx_done | input | 1 | Transmission finished pulse |
| mac_tx_fail | input | 1 | Failure qualifier, valid with `mac_tx_done` |
| mac_rx_frame | input | 1 | Frame received pulse |
| tx_start | output | 1 | One-cycle transmit launch pulse |
| tx_ack_req | output | 1 | Acknowledgement requested for the frame |
| irq_n | output | 1 | Active-low level interrupt |

## Verification
The two functions that can collide are the clear-on-read of the event register and the setting of an event bit by a packet-engine pulse. The bench raises `mac_rx_frame` in the very cycle it strobes a read of the event register, then checks that the returned byte lacks the new bit while a following read shows it, proving the set wins over the clear. A launch written while a transmission is in flight is a second overlap, judged by watching `tx_start` stay low until completion.

// File: rtl/txirq_pkg.sv
package txirq_pkg;

    // Bit positions decoded by software; kept fixed.
    localparam int EVT_N        = 2;
    localparam int EVT_POS [EVT_N] = '{0, 3};   // transmit done, frame received
    localparam int CTL_TRIG     = 0;
    localparam int CTL_ACK      = 2;
    localparam int RES_FAIL     = 0;

    typedef struct packed {
        logic trig;
        logic ack;
        logic busy;
        logic fail;
    } launch_t;

endpackage

// File: rtl/txirq_evt_status.sv
module txirq_evt_status #(
    parameter int EVT_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_N-1:0] set_vec,
    input  logic             clr,
    output logic [EVT_N-1:0] stat_q
);

    for (genvar g = 0; g < EVT_N; g++) begin : g_evt
        logic bit_d;
        logic bit_q;

        always_comb begin
            bit_d = (bit_q & ~clr) | set_vec[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
        end

        assign stat_q[g] = bit_q;

        AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[g] |=> stat_q[g]);                    // R6
        AST_EVT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !set_vec[g]) |=> !stat_q[g]);         // R6
    end

endmodule

// File: rtl/txirq_tx_launch.sv
module txirq_tx_launch
    import txirq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_ctl,
    input  logic    wr_trig,
    input  logic    wr_ack,
    input  logic    tx_done,
    input  logic    tx_fail,
    output logic    tx_start,
    output logic    ack_req,
    output logic    trig_rd,
    output logic    fail_rd
);

    launch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.trig) begin
            st_d.trig = 1'b0;
            st_d.busy = 1'b1;
        end else if (tx_done) begin
            st_d.busy = 1'b0;
        end
        if (tx_done) st_d.fail = tx_fail;
        if (wr_ctl) begin
            st_d.ack = wr_ack;
            if (wr_trig && !st_q.busy && !st_q.trig) st_d.trig = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_start = st_q.trig;
    assign ack_req  = st_q.ack;
    assign trig_rd  = st_q.trig;
    assign fail_rd  = st_q.fail;

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);                          // R2
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> !tx_start);                         // R4
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_done |=> $stable(fail_rd));                   // R8

endmodule

// File: rtl/txirq_irq_gen.sv
module txirq_irq_gen #(
    parameter int               EVT_N   = 2,
    parameter logic [EVT_N-1:0] RST_DIS = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dis,
    input  logic [EVT_N-1:0] dis_wdata,
    input  logic [EVT_N-1:0] stat,
    output logic [EVT_N-1:0] dis_q,
    output logic             irq_n
);

    logic [EVT_N-1:0] dis_d;

    always_comb begin
        dis_d = wr_dis ? dis_wdata : dis_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dis_q <= RST_DIS;
        else        dis_q <= dis_d;
    end

    assign irq_n = ~|(stat & ~dis_q);

    AST_IRQ_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '0) |-> irq_n);                          // R7

endmodule

// File: rtl/txirq_ctrl.sv
module txirq_ctrl
    import txirq_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 6,
    parameter logic [ADDR_W-1:0] ADDR_EVT  = 6'h00,
    parameter logic [ADDR_W-1:0] ADDR_DIS  = 6'h01,
    parameter logic [ADDR_W-1:0] ADDR_CTL  = 6'h02,
    parameter logic [ADDR_W-1:0] ADDR_RES  = 6'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              mac_tx_done,
    input  logic              mac_tx_fail,
    input  logic              mac_rx_frame,
    output logic              tx_start,
    output logic              tx_ack_req,
    output logic              irq_n
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    logic             hit_evt, hit_dis, hit_ctl, hit_res;
    logic [EVT_N-1:0] evt_set, evt_stat, dis_wdata, dis_q;
    logic [DATA_W-1:0] evt_full, dis_full, ctl_full, res_full;
    logic             trig_rd, fail_rd;

    assign hit_evt = (reg_addr == ADDR_EVT);
    assign hit_dis = (reg_addr == ADDR_DIS);
    assign hit_ctl = (reg_addr == ADDR_CTL);
    assign hit_res = (reg_addr == ADDR_RES);

    assign evt_set = {mac_rx_frame, mac_tx_done};

    // Spread the compact event/disable vectors onto their register bits.
    for (genvar k = 0; k < EVT_N; k++) begin : g_map
        assign dis_wdata[k] = reg_wdata[EVT_POS[k]];
    end

    always_comb begin
        evt_full = '0;
        dis_full = '0;
        for (int k = 0; k < EVT_N; k++) begin
            evt_full[EVT_POS[k]] = evt_stat[k];
            dis_full[EVT_POS[k]] = dis_q[k];
        end
        ctl_full = '0;
        ctl_full[CTL_TRIG] = trig_rd;
        ctl_full[CTL_ACK]  = tx_ack_req;
        res_full = '0;
        res_full[RES_FAIL] = fail_rd;
    end

    txirq_evt_status #(.EVT_N(EVT_N)) u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (evt_set),
        .clr     (reg_rd && hit_evt),
        .stat_q  (evt_stat)
    );

    txirq_irq_gen #(.EVT_N(EVT_N), .RST_DIS('1)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_dis    (reg_wr && hit_dis),
        .dis_wdata (dis_wdata),
        .stat      (evt_stat),
        .dis_q     (dis_q),
        .irq_n     (irq_n)
    );

    txirq_tx_launch u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl   (reg_wr && hit_ctl),
        .wr_trig  (reg_wdata[CTL_TRIG]),
        .wr_ack   (reg_wdata[CTL_ACK]),
        .tx_done  (mac_tx_done),
        .tx_fail  (mac_tx_fail),
        .tx_start (tx_start),
        .ack_req  (tx_ack_req),
        .trig_rd  (trig_rd),
        .fail_rd  (fail_rd)
    );

    always_comb begin
        rd_d = rd_q;
        if (reg_rd) begin
            unique case (1'b1)
                hit_evt: rd_d.rdata = evt_full;
                hit_dis: rd_d.rdata = dis_full;
                hit_ctl: rd_d.rdata = ctl_full;
                hit_res: rd_d.rdata = res_full;
                default: rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign reg_rdata = rd_q.rdata;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));                  // R9
    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (evt_full != '0));                     // R7

endmodule

// File: tb/txirq_ctrl_tb.sv
module txirq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] A_EVT = 6'h00, A_DIS = 6'h01, A_CTL = 6'h02, A_RES = 6'h03;

    // op: 0 write, 1 read and compare, 2 event pulse (data b0 done, b1 fail, b2 rx), 3 compare irq_n
    typedef struct packed {
        logic [1:0] op;
        logic [5:0] addr;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{2'd1, A_DIS, 8'h00, 8'h09, 4'd1},  // R1 disable reset value
        '{2'd2, A_EVT, 8'h04, 8'h00, 4'd5},  // R5 receive pulse
        '{2'd3, A_EVT, 8'h00, 8'h01, 4'd7},  // R7 masked: irq_n high
        '{2'd0, A_DIS, 8'h00, 8'h00, 4'd7},  // R7 enable all
        '{2'd3, A_EVT, 8'h00, 8'h00, 4'd7},  // R7 irq_n low
        '{2'd1, A_EVT, 8'h00, 8'h08, 4'd5},  // R5 bit 3 set
        '{2'd3, A_EVT, 8'h00, 8'h01, 4'd6},  // R6 cleared by read
        '{2'd1, A_EVT, 8'h00, 8'h00, 4'd6},  // R6 reads empty
        '{2'd0, A_EVT, 8'hFF, 8'h00, 4'd5},  // R5 write ignored
        '{2'd1, A_EVT, 8'h00, 8'h00, 4'd5},  // R5 still empty
        '{2'd0, A_DIS, 8'hFF, 8'h00, 4'd7},
        '{2'd1, A_DIS, 8'h00, 8'h09, 4'd7},  // R7 only two bits stored
        '{2'd0, A_CTL, 8'h04, 8'h00, 4'd3},
        '{2'd1, A_CTL, 8'h00, 8'h04, 4'd3},  // R3 ack reads back
        '{2'd0, A_CTL, 8'h00, 8'h00, 4'd3},
        '{2'd1, A_CTL, 8'h00, 8'h00, 4'd3},  // R3 ack cleared
        '{2'd1, 6'h2A, 8'h00, 8'h00, 4'd10}  // R10 unmapped
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 0, reg_rd = 0, mac_tx_done = 0, mac_tx_fail = 0, mac_rx_frame = 0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic tx_start, tx_ack_req, irq_n;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txirq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mac_tx_done(mac_tx_done), .mac_tx_fail(mac_tx_fail), .mac_rx_frame(mac_rx_frame),
        .tx_start(tx_start), .tx_ack_req(tx_ack_req), .irq_n(irq_n)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic do_read(input logic [5:0] a, output logic [7:0] d);
        reg_rd = 1; reg_addr = a;
        @(posedge clk); @(negedge clk);
        reg_rd = 0;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic done, input logic fail, input logic rx);
        mac_tx_done = done; mac_tx_fail = fail; mac_rx_frame = rx;
        @(posedge clk); @(negedge clk);
        mac_tx_done = 0; mac_tx_fail = 0; mac_rx_frame = 0;
    endtask

    initial begin
        logic [7:0] rd;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check({7'd0, irq_n}, 8'h01, "R1 irq_n");
        check({6'd0, tx_start, tx_ack_req}, 8'h00, "R1 start/ack");
        do_read(A_EVT, rd); check(rd, 8'h00, "R1 event reg");

        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            case (VECS[i].op)
                2'd0: do_write(VECS[i].addr, VECS[i].data);
                2'd1: begin do_read(VECS[i].addr, rd); check(rd, VECS[i].exp, tag); end
                2'd2: pulse(VECS[i].data[0], VECS[i].data[1], VECS[i].data[2]);
                default: check({7'd0, irq_n}, VECS[i].exp, tag);
            endcase
        end

        // R2 launch pulse timing
        do_write(A_CTL, 8'h01);
        check({7'd0, tx_start}, 8'h01, "R2 start pulse");
        @(negedge clk);
        check({7'd0, tx_start}, 8'h00, "R2 single cycle");
        do_read(A_CTL, rd); check(rd, 8'h00, "R2 trigger self-clears");

        // R4 launch during flight ignored
        do_write(A_CTL, 8'h01);
        check({7'd0, tx_start}, 8'h00, "R4 busy ignore a");
        @(negedge clk);
        check({7'd0, tx_start}, 8'h00, "R4 busy ignore b");
        pulse(1, 1, 0);
        do_read(A_RES, rd); check(rd, 8'h01, "R8 failure recorded");
        do_read(A_EVT, rd); check(rd, 8'h01, "R5 tx done bit 0");
        do_write(A_CTL, 8'h01);
        check({7'd0, tx_start}, 8'h01, "R4 accepted after done");
        @(negedge clk);
        pulse(1, 0, 0);
        do_read(A_RES, rd); check(rd, 8'h00, "R8 success recorded");
        do_read(A_EVT, rd);

        // R9 read data holds across a write
        do_read(A_DIS, rd);
        do_write(A_DIS, 8'h08);
        check(reg_rdata, 8'h09, "R9 rdata held");

        // R7 transmit enabled, receive disabled
        pulse(0, 0, 1);
        check({7'd0, irq_n}, 8'h01, "R7 rx disabled");
        pulse(1, 0, 0);
        check({7'd0, irq_n}, 8'h00, "R7 tx enabled");
        do_write(A_DIS, 8'h09);
        check({7'd0, irq_n}, 8'h01, "R7 disable masks line");
        do_read(A_EVT, rd); check(rd, 8'h09, "R5 both events");

        // R6 event in the same cycle as the clearing read
        reg_rd = 1; reg_addr = A_EVT; mac_rx_frame = 1;
        @(posedge clk); @(negedge clk);
        reg_rd = 0; mac_rx_frame = 0;
        check(reg_rdata, 8'h00, "R6 read shows old contents");
        do_read(A_EVT, rd); check(rd, 8'h08, "R6 same-cycle event kept");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule